// File: doc/BRIEF.md
# I2C Potentiometer Register Slave

This block is the serial front end of a dual 256-position digital potentiometer controller. It listens on a two-wire I2C-compatible bus with a fast system clock. It finds START and STOP conditions on the bus and answers one 7-bit device address. That address is a fixed four-bit prefix followed by three strap inputs. Each accepted transaction is always three bytes: address plus flag, command, and data. The block acknowledges each byte by pulling SDA low through the ninth clock.

When a complete frame ends with STOP, the command is applied. It can load one of two 8-bit wiper registers or one of two shadow non-volatile registers. It can also copy in either direction between a wiper and its shadow. Any action that touches non-volatile state is blocked while the write-protect input is high. SDA is open-drain: the block only asserts a pull-down enable. SCL is input only. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_pot_slave`

## Requirements
- R1: After reset both wipers and both shadow registers read 0x80 and the SDA pull-down is released.
- R2: The device address is 0101 followed by strap bits [2:1:0] (strap[2] most significant). When the first seven bits after START match it, SDA is held low for the whole high phase of the ninth SCL pulse.
- R3: On an address mismatch no byte is acknowledged and no register changes. The block ignores the bus until the next START or STOP.
- R4: The command byte and the data byte of an addressed frame are each acknowledged on their ninth clock.
- R5: Command bits [2:1]=00 load the data byte into the wiper chosen by command bit 0 (0 = wiper A, 1 = wiper B).
- R6: Command bits [2:1]=01 load the data byte into the chosen shadow register, only while write-protect is low.
- R7: Command bits [2:1]=10 copy the chosen wiper into its shadow register, only while write-protect is low.
- R8: Command bits [2:1]=11 copy the chosen shadow register into its wiper, only while write-protect is low.
- R9: When the eighth address bit (flag) is 1, the frame is acknowledged but no register changes.
- R10: A frame cut off by STOP before its data byte is complete changes no register.
- R11: Registers keep their values after the data byte is acknowledged, and change only on the following STOP.
- R12: A repeated START in mid-frame discards the partial frame and begins a new address reception.
- R13: A command byte with any of bits [7:3] set is acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release |
| strap_i | input | 3 | Address strap bits, [2] most significant |
| wp_i | input | 1 | Write-protect for shadow registers, active high |
| wiper_a_o | output | 8 | Wiper A position |
| wiper_b_o | output | 8 | Wiper B position |
| nv_a_o | output | 8 | Shadow register A |
| nv_b_o | output | 8 | Shadow register B |

## Verification
A bit counter that slips, or a wrong state after a repeated START, shows up at the ports within the same frame. The acknowledge appears on the wrong clock pulse or not at all, and the bench samples SDA on every ninth pulse. A wrong command latch or a missed write-protect gate shows a few system clocks after STOP, as a wrong value on one of the four register outputs. Checking the register outputs between the data acknowledge and STOP catches a commit that fires early.

// File: rtl/i2cpot_pkg.sv
package i2cpot_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_CMD,
    LS_DATA,
    LS_FULL,
    LS_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    ACT_SET_WIPER = 2'b00,
    ACT_SET_NV    = 2'b01,
    ACT_SAVE      = 2'b10,
    ACT_RECALL    = 2'b11
  } pot_act_t;
endpackage

// File: rtl/i2cpot_sync.sv
module i2cpot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_d
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_n;
  logic              hold;

  always_comb begin
    chain_n = {chain[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      hold  <= 1'b1;
    end else begin
      chain <= chain_n;
      hold  <= chain[STAGES-1];
    end
  end

  assign q   = chain[STAGES-1];
  assign q_d = hold;
endmodule

// File: rtl/i2cpot_link.sv
module i2cpot_link
  import i2cpot_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          scl_q,
  input  logic          sda_s,
  input  logic          sda_q,
  input  logic [6:0]    dev_addr,
  output logic          sda_pull,
  output logic          commit,
  output logic [DW-1:0] cmd,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DW + 1);

  link_st_t      st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] sh, sh_n, cmd_n, data_n;
  logic          ack, ack_n, flag, flag_n, commit_n;

  logic scl_rise, scl_fall, bus_start, bus_stop, byte_full, active;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_full = (cnt == CW'(DW));
  assign active    = (st == LS_ADDR) || (st == LS_CMD) || (st == LS_DATA);

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; ack_n = ack; flag_n = flag;
    cmd_n = cmd; data_n = data; commit_n = 1'b0;
    if (bus_start) begin
      st_n = LS_ADDR; cnt_n = '0; ack_n = 1'b0;
    end else if (bus_stop) begin
      commit_n = (st == LS_FULL) && !flag;
      st_n = LS_IDLE; cnt_n = '0; ack_n = 1'b0;
    end else if (active) begin
      if (scl_rise && !ack && !byte_full) begin
        sh_n  = {sh[DW-2:0], sda_s};
        cnt_n = cnt + CW'(1);
      end else if (scl_fall && ack) begin
        ack_n = 1'b0;
        cnt_n = '0;
        case (st)
          LS_ADDR: st_n = LS_CMD;
          LS_CMD:  st_n = LS_DATA;
          default: st_n = LS_FULL;
        endcase
      end else if (scl_fall && byte_full) begin
        if (st == LS_ADDR && sh[DW-1:1] != dev_addr) begin
          st_n  = LS_SKIP;
          cnt_n = '0;
        end else begin
          ack_n = 1'b1;
          case (st)
            LS_ADDR: flag_n = sh[0];
            LS_CMD:  cmd_n  = sh;
            default: data_n = sh;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LS_IDLE; cnt <= '0; sh <= '0; ack <= 1'b0; flag <= 1'b1;
      cmd <= '0; data <= '0; commit <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; ack <= ack_n; flag <= flag_n;
      cmd <= cmd_n; data <= data_n; commit <= commit_n;
    end
  end

  assign sda_pull = ack;
endmodule

// File: rtl/i2cpot_regs.sv
module i2cpot_regs
  import i2cpot_pkg::*;
#(
  parameter int          DW      = BYTE_W,
  parameter logic [7:0]  RST_VAL = 8'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [DW-1:0]           cmd,
  input  logic [DW-1:0]           data,
  input  logic                    wp,
  output logic [NCH-1:0][DW-1:0]  wiper,
  output logic [NCH-1:0][DW-1:0]  nv
);
  logic     cmd_ok;
  pot_act_t act;
  assign cmd_ok = (cmd[DW-1:3] == '0);
  assign act    = pot_act_t'(cmd[2:1]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] w_n, n_n;
    logic          hit;
    assign hit = commit && cmd_ok && (cmd[0] == 1'(g));

    always_comb begin
      w_n = wiper[g];
      n_n = nv[g];
      if (hit) begin
        case (act)
          ACT_SET_WIPER: w_n = data;
          ACT_SET_NV:    if (!wp) n_n = data;
          ACT_SAVE:      if (!wp) n_n = wiper[g];
          default:       if (!wp) w_n = nv[g];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper[g] <= DW'(RST_VAL);
        nv[g]    <= DW'(RST_VAL);
      end else if (hit) begin
        wiper[g] <= w_n;
        nv[g]    <= n_n;
      end
    end
  end
endmodule

// File: rtl/i2c_pot_slave.sv
module i2c_pot_slave
  import i2cpot_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0101,
  parameter logic [7:0] RST_VAL     = 8'h80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic [7:0] wiper_a_o,
  output logic [7:0] wiper_b_o,
  output logic [7:0] nv_a_o,
  output logic [7:0] nv_b_o
);
  logic scl_s, scl_q, sda_s, sda_q;
  logic commit_w;
  logic [BYTE_W-1:0] cmd_w, data_w;
  logic [NCH-1:0][BYTE_W-1:0] wiper_w, nv_w;

  i2cpot_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s), .q_d(scl_q));
  i2cpot_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s), .q_d(sda_q));

  i2cpot_link #(.DW(BYTE_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
    .dev_addr({ADDR_PREFIX, strap_i}),
    .sda_pull(sda_pull_o), .commit(commit_w), .cmd(cmd_w), .data(data_w));

  i2cpot_regs #(.DW(BYTE_W), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .cmd(cmd_w), .data(data_w),
    .wp(wp_i), .wiper(wiper_w), .nv(nv_w));

  assign wiper_a_o = wiper_w[0];
  assign wiper_b_o = wiper_w[1];
  assign nv_a_o    = nv_w[0];
  assign nv_b_o    = nv_w[1];
endmodule

// File: rtl/i2c_pot_slave_chk.sv
module i2c_pot_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       wp_i,
  input logic       commit_w,
  input logic       sda_pull_o,
  input logic [7:0] wiper_a_o,
  input logic [7:0] wiper_b_o,
  input logic [7:0] nv_a_o,
  input logic [7:0] nv_b_o
);
  // R11
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> ($stable(wiper_a_o) && $stable(wiper_b_o)));

  // R11
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> ($stable(nv_a_o) && $stable(nv_b_o)));

  // R6
  nv_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |=> ($stable(nv_a_o) && $stable(nv_b_o)));

  // R10
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> !commit_w);

  // R2
  ack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));
endmodule

bind i2c_pot_slave i2c_pot_slave_chk u_chk (.*);

// File: tb/i2c_pot_slave_test.sv
module i2c_pot_slave_test;
  localparam int Q = 5;

  typedef struct {
    logic [7:0] wa, wb, na, nb;
    string      tag;
  } snap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic sda_pull, sda_bus;
  logic [7:0] wa, wb, na, nb;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mw [2];
  logic [7:0] mn [2];
  snap_t exp_q[$];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_pot_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .strap_i(strap), .wp_i(wp),
    .wiper_a_o(wa), .wiper_b_o(wb), .nv_a_o(na), .nv_b_o(nb));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(2 * Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic seen;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    seen = ~sda_bus;
    wait_q(Q - 1);
    seen = seen & ~sda_bus;
    wait_q(1);
    scl_m = 1'b0; wait_q(Q);
    chk(exp_ack ? {tag, " ack"} : "R3 no ack", 32'(seen), 32'(exp_ack));
  endtask

  task automatic apply(input logic [7:0] cmd, input logic [7:0] dat, input logic flag);
    int s;
    if (flag || cmd[7:3] != 5'd0) return;
    s = int'(cmd[0]);
    case (cmd[2:1])
      2'b00: mw[s] = dat;
      2'b01: if (!wp) mn[s] = dat;
      2'b10: if (!wp) mn[s] = mw[s];
      default: if (!wp) mw[s] = mn[s];
    endcase
  endtask

  task automatic push(input string tag);
    snap_t e;
    e.wa = mw[0]; e.wb = mw[1]; e.na = mn[0]; e.nb = mn[1]; e.tag = tag;
    exp_q.push_back(e);
    wait_q(30);
  endtask

  task automatic frame(input logic [7:0] abyte, input bit ok, input logic [7:0] cmd,
                       input logic [7:0] dat, input string tag);
    bus_start();
    send_byte(abyte, ok, "R2");
    send_byte(cmd, ok, "R4");
    send_byte(dat, ok, "R4");
    chk("R11 wiperA before stop", 32'(wa), 32'(mw[0]));
    chk("R11 wiperB before stop", 32'(wb), 32'(mw[1]));
    bus_stop();
    if (ok) apply(cmd, dat, abyte[0]);
    push(tag);
  endtask

  // monitor: pops expected register images and compares
  initial begin
    forever begin
      snap_t e;
      wait (exp_q.size() > 0);
      wait_q(10);
      e = exp_q.pop_front();
      chk({e.tag, " wiperA"}, 32'(wa), 32'(e.wa));
      chk({e.tag, " wiperB"}, 32'(wb), 32'(e.wb));
      chk({e.tag, " nvA"},    32'(na), 32'(e.na));
      chk({e.tag, " nvB"},    32'(nb), 32'(e.nb));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    mw[0] = 8'h80; mw[1] = 8'h80; mn[0] = 8'h80; mn[1] = 8'h80;
    wait_q(5);
    rst_n = 1'b1;
    wait_q(5);
    chk("R1 pull released", 32'(sda_pull), 32'd0);
    push("R1 reset");
    // strap 101 -> address 0101101, write byte 0x5A
    frame(8'h5A, 1'b1, 8'h00, 8'h3C, "R5 wiperA");
    frame(8'h5A, 1'b1, 8'h01, 8'hC3, "R5 wiperB");
    frame(8'h5A, 1'b1, 8'h02, 8'h11, "R6 nvA");
    wp = 1'b1;
    frame(8'h5A, 1'b1, 8'h03, 8'h22, "R6 nvB protected");
    wp = 1'b0;
    frame(8'h5A, 1'b1, 8'h05, 8'h00, "R7 saveB");
    wp = 1'b1;
    frame(8'h5A, 1'b1, 8'h06, 8'h00, "R8 recallA protected");
    wp = 1'b0;
    frame(8'h5A, 1'b1, 8'h06, 8'h00, "R8 recallA");
    frame(8'h5B, 1'b1, 8'h00, 8'h99, "R9 flag set");
    frame(8'h5E, 1'b0, 8'h00, 8'h44, "R3 mismatch");
    frame(8'h5A, 1'b1, 8'h08, 8'h77, "R13 bad cmd");
    // R10 truncated data byte
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    send_byte(8'h01, 1'b1, "R4");
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    push("R10 truncated");
    // R12 repeated start
    bus_start();
    send_byte(8'h5A, 1'b1, "R2");
    send_byte(8'h01, 1'b1, "R4");
    bit_out(1'b0);
    bus_start();
    send_byte(8'h5A, 1'b1, "R12 readdress");
    send_byte(8'h00, 1'b1, "R12 cmd");
    send_byte(8'h5D, 1'b1, "R12 data");
    bus_stop();
    apply(8'h00, 8'h5D, 1'b0);
    push("R12 restart");
    // R2 other strap
    strap = 3'b000;
    wait_q(5);
    frame(8'h50, 1'b1, 8'h01, 8'hAB, "R2 strap000");
    frame(8'h5A, 1'b0, 8'h00, 8'h12, "R3 old address");
    wait (exp_q.size() == 0);
    wait_q(20);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule